// File: doc/BRIEF.md
# Complete-Cycle LFSR Exhaustive Pattern Generator

This block produces stimulus for exhaustive testing of a small combinational circuit. Its pattern register walks through every one of the 2^WIDTH input vectors exactly once per period, with no repeats. The default source is a maximal-length shift-register sequence. Its feedback is altered so that the all-zero vector also lies on the cycle, which makes the cycle 2^WIDTH states long instead of 2^WIDTH-1. A plain binary up-counter can be chosen instead through the `mode` input, for comparison.

A user resets the block or loads a seed, then holds `enable` high. One pattern is produced per enabled clock. Dropping `enable` freezes the pattern without losing the position in the period. The `done` output pulses for one cycle once a full period has been applied, at which point the pattern equals the seed again. `WIDTH` is limited to 2..22, since longer exhaustive runs are impractical. The design refuses to elaborate outside that range.

A small sequencer drives `done`. Its states are:

- ST_PAUSE: no step was taken on the last edge, after a reset or a load.
- ST_SWEEP: a step was taken that did not close the period.
- ST_WRAP: the last step closed the period.

Its transitions are:

- T_LOAD: from any state to ST_PAUSE when `load` is high.
- T_IDLE: from any state to ST_PAUSE when `enable` is low.
- T_ADVANCE: to ST_SWEEP on a step that is not the last of the period.
- T_CLOSE: to ST_WRAP on the step that ends the period.

Top module: `cltpg_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pattern` becomes SEED_INIT (default 1, never zero) and `done` goes low.
- R2: When `load` is high, the next edge puts `seed` on `pattern` whatever `enable` is. It also restarts the period count and clears `done`.
- R3: With `load` and `enable` both low, `pattern` keeps its value and `done` is low after the edge.
- R4: In mode 0 (shift mode), each step shifts `pattern` right by one. The new top bit is the XOR of the tapped bits, further XORed with 1 when bits WIDTH-1..1 are all zero. For WIDTH 4 the taps are bits 3 and 0, so 1000 steps to 1100. For WIDTH 8 the taps are bits 6, 5, 4 and 0, so 0x80 steps to 0x40.
- R5: In mode 0, the pattern 0..01 steps to all zeros, and all zeros steps to 10..0.
- R6: In mode 0, any 2^WIDTH consecutive patterns starting from any seed, zero included, are all distinct.
- R7: In mode 1 (count mode), each step adds one modulo 2^WIDTH, so the all-ones pattern steps to zero.
- R8: `done` is high for exactly one cycle. It rises in the cycle where `pattern` has just returned to the seed after 2^WIDTH enabled steps since the last load or reset. Pauses with `enable` low do not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance one pattern per clock while high |
| load | input | 1 | Load `seed` into the pattern register; wins over `enable` |
| mode | input | 1 | 0 = complete shift sequence, 1 = binary count |
| seed | input | WIDTH | Start value for a load |
| pattern | output | WIDTH | Current test vector |
| done | output | 1 | One-cycle pulse when a full period has been applied |

## Verification
A wrong feedback tap or a missing zero insertion makes some vector repeat inside one period. The uniqueness check across a whole period catches this within 2^WIDTH enabled cycles. A single step from a known vector shows it at the very next sample. A period counter that is off by one, or a sequencer that keeps a stale state, moves or stretches the `done` pulse. That shows within one period, because the pulse is also compared against the seed value on `pattern`. Load-priority and hold faults appear one cycle after the offending edge.

// File: rtl/cltpg_pkg.sv
package cltpg_pkg;

    localparam int unsigned WIDTH_MIN = 2;
    localparam int unsigned WIDTH_MAX = 22;

    typedef enum logic {
        GEN_SHIFT = 1'b0,
        GEN_COUNT = 1'b1
    } gen_mode_e;

    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_SWEEP = 2'd1,
        ST_WRAP  = 2'd2
    } seq_state_e;

    // Feedback masks of primitive polynomials for a right-shifting register.
    // Bit 0 is always set, so the stage being shifted out is always a tap.
    function automatic logic [31:0] tap_mask(input int unsigned w);
        logic [31:0] m;
        case (w)
            2:       m = (32'd1 << 1)  | 32'd1;
            3:       m = (32'd1 << 2)  | 32'd1;
            4:       m = (32'd1 << 3)  | 32'd1;
            5:       m = (32'd1 << 3)  | 32'd1;
            6:       m = (32'd1 << 5)  | 32'd1;
            7:       m = (32'd1 << 6)  | 32'd1;
            8:       m = (32'd1 << 6)  | (32'd1 << 5) | (32'd1 << 4) | 32'd1;
            9:       m = (32'd1 << 5)  | 32'd1;
            10:      m = (32'd1 << 7)  | 32'd1;
            11:      m = (32'd1 << 9)  | 32'd1;
            12:      m = (32'd1 << 11) | (32'd1 << 10) | (32'd1 << 4) | 32'd1;
            13:      m = (32'd1 << 12) | (32'd1 << 11) | (32'd1 << 8) | 32'd1;
            14:      m = (32'd1 << 13) | (32'd1 << 12) | (32'd1 << 2) | 32'd1;
            15:      m = (32'd1 << 14) | 32'd1;
            16:      m = (32'd1 << 15) | (32'd1 << 13) | (32'd1 << 4) | 32'd1;
            17:      m = (32'd1 << 14) | 32'd1;
            18:      m = (32'd1 << 11) | 32'd1;
            19:      m = (32'd1 << 18) | (32'd1 << 17) | (32'd1 << 14) | 32'd1;
            20:      m = (32'd1 << 17) | 32'd1;
            21:      m = (32'd1 << 19) | 32'd1;
            22:      m = (32'd1 << 21) | 32'd1;
            default: m = 32'd1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cltpg_shift_next.sv
module cltpg_shift_next
    import cltpg_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [31:0]      MASK_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAPS      = MASK_FULL[WIDTH-1:0];

    logic lin_fb;
    logic upper_clear;

    always_comb begin
        lin_fb      = ^(cur & TAPS);
        // Only 0..01 and 0..00 have every stage but the outgoing one clear.
        // Flipping the feedback there splices zero into the cycle.
        upper_clear = ~|cur[WIDTH-1:1];
        nxt         = {lin_fb ^ upper_clear, cur[WIDTH-1:1]};
    end

endmodule

// File: rtl/cltpg_count_next.sv
module cltpg_count_next #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] INC = WIDTH'(1);

    always_comb begin
        nxt = cur + INC;
    end

endmodule

// File: rtl/cltpg_period_ctr.sv
module cltpg_period_ctr #(
    parameter int unsigned WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] INC  = WIDTH'(1);

    logic [WIDTH-1:0] steps_taken;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            steps_taken <= '0;
        end else if (step) begin
            steps_taken <= steps_taken + INC;
        end
    end

    always_comb begin
        last = step && (steps_taken == FULL);
    end

    // R8: the count wraps to zero on the closing step, so the next period is also 2^WIDTH long.
    assert_ctr_wraps_R8: assert property (@(posedge clk) disable iff (rst)
        (last && !clear) |=> (steps_taken == '0));

endmodule

// File: rtl/cltpg_top.sv
module cltpg_top
    import cltpg_pkg::*;
#(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     SEED_INIT = WIDTH'(1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             load,
    input  logic             mode,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] pattern,
    output logic             done
);

    localparam logic [WIDTH-1:0] PAT_ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] PAT_ZERO = '0;
    localparam logic [WIDTH-1:0] PAT_MSB  = {1'b1, {(WIDTH-1){1'b0}}};

    generate
        if (WIDTH < WIDTH_MIN || WIDTH > WIDTH_MAX) begin : g_bad_width
            $error("cltpg_top: WIDTH must lie in 2..22");
        end
        if (SEED_INIT == '0) begin : g_bad_seed
            $error("cltpg_top: SEED_INIT must be nonzero");
        end
    endgenerate

    gen_mode_e        gen_sel;
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             step;
    logic             period_last;
    logic [WIDTH-1:0] shift_nxt;
    logic [WIDTH-1:0] count_nxt;
    logic [WIDTH-1:0] pat_nxt;

    always_comb begin
        gen_sel = gen_mode_e'(mode);
        step    = enable && !load;
    end

    cltpg_shift_next #(.WIDTH(WIDTH)) u_shift (
        .cur (pattern),
        .nxt (shift_nxt)
    );

    cltpg_count_next #(.WIDTH(WIDTH)) u_count (
        .cur (pattern),
        .nxt (count_nxt)
    );

    cltpg_period_ctr #(.WIDTH(WIDTH)) u_period (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .step  (step),
        .last  (period_last)
    );

    always_comb begin
        unique case (gen_sel)
            GEN_SHIFT: pat_nxt = shift_nxt;
            GEN_COUNT: pat_nxt = count_nxt;
            default:   pat_nxt = shift_nxt;
        endcase
    end

    // Pattern register
    always_ff @(posedge clk) begin
        if (rst) begin
            pattern <= SEED_INIT;
        end else if (load) begin
            pattern <= seed;
        end else if (step) begin
            pattern <= pat_nxt;
        end
    end

    // Sequencer: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAUSE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequencer: next state
    always_comb begin
        state_d = ST_PAUSE;
        unique case (state_q)
            ST_PAUSE, ST_SWEEP, ST_WRAP: begin
                if (load) begin
                    state_d = ST_PAUSE;                        // T_LOAD
                end else if (!enable) begin
                    state_d = ST_PAUSE;                        // T_IDLE
                end else if (period_last) begin
                    state_d = ST_WRAP;                         // T_CLOSE
                end else begin
                    state_d = ST_SWEEP;                        // T_ADVANCE
                end
            end
            default: state_d = ST_PAUSE;
        endcase
    end

    // Sequencer: outputs
    always_comb begin
        unique case (state_q)
            ST_WRAP:  done = 1'b1;
            ST_PAUSE: done = 1'b0;
            ST_SWEEP: done = 1'b0;
            default:  done = 1'b0;
        endcase
    end

    assert_load_takes_seed_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (pattern == $past(seed)) && !done);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && !enable) |=> $stable(pattern) && !done);

    assert_zero_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (step && gen_sel == GEN_SHIFT && pattern == PAT_ONE) |=> (pattern == PAT_ZERO));

    assert_zero_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (step && gen_sel == GEN_SHIFT && pattern == PAT_ZERO) |=> (pattern == PAT_MSB));

    assert_shift_right_R4: assert property (@(posedge clk) disable iff (rst)
        (step && gen_sel == GEN_SHIFT) |=> (pattern[WIDTH-2:0] == $past(pattern[WIDTH-1:1])));

    assert_count_inc_R7: assert property (@(posedge clk) disable iff (rst)
        (step && gen_sel == GEN_COUNT) |=> (pattern == $past(pattern) + PAT_ONE));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_step_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(step));

endmodule

// File: tb/sim_cltpg_top.sv
`timescale 1ns/1ps
module sim_cltpg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        load = 1'b0;
    logic        mode = 1'b0;
    logic [10:0] seed = '0;

    logic [7:0]  pat0;
    logic [3:0]  pat1;
    logic [10:0] pat2;
    logic        done0, done1, done2;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cltpg_top #(.WIDTH(8)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .load(load), .mode(mode),
        .seed(seed[7:0]), .pattern(pat0), .done(done0));

    cltpg_top #(.WIDTH(4)) u1 (
        .clk(clk), .rst(rst), .enable(enable), .load(load), .mode(mode),
        .seed(seed[3:0]), .pattern(pat1), .done(done1));

    cltpg_top #(.WIDTH(11)) u2 (
        .clk(clk), .rst(rst), .enable(enable), .load(load), .mode(mode),
        .seed(seed), .pattern(pat2), .done(done2));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_seed(input logic m, input logic [10:0] s, input logic en_v);
        @(negedge clk);
        mode = m; seed = s; load = 1'b1; enable = en_v;
        @(negedge clk);
        load = 1'b0; enable = 1'b0;
    endtask

    // R1: reset value and done low
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(pat0 == 8'h01, "R1", "u0 pattern in reset", pat0, 1);
        check(pat2 == 11'h001 && !done0 && !done2, "R1", "u2 pattern/done in reset", pat2, 1);
        rst = 1'b0;
        @(negedge clk);
        check(pat1 == 4'h1 && !done1, "R1", "u1 pattern after reset", pat1, 1);
    endtask

    // R3: hold with enable and load low
    task automatic t_hold();
        int bad = 0;
        load_seed(1'b0, 11'h0F3, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (pat0 != 8'hF3 || pat2 != 11'h0F3 || done0 || done2) bad++;
        end
        check(bad == 0, "R3", "cycles where pattern moved while idle", bad, 0);
    endtask

    // R4 and R5: single steps through the zero splice and onward
    task automatic t_zero_splice();
        load_seed(1'b0, 11'h001, 1'b0);
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
        check(pat1 == 4'h0 && pat0 == 8'h00 && pat2 == 11'h000, "R5", "0..01 to zero", pat0, 0);
        @(negedge clk);
        check(pat1 == 4'h8, "R5", "u1 zero to msb", pat1, 8);
        check(pat0 == 8'h80 && pat2 == 11'h400, "R5", "u0/u2 zero to msb", pat0, 8'h80);
        @(negedge clk);
        enable = 1'b0;
        check(pat1 == 4'hC, "R4", "u1 step from 1000", pat1, 4'hC);
        check(pat0 == 8'h40, "R4", "u0 step from 0x80", pat0, 8'h40);
    endtask

    // R7: count mode wraps
    task automatic t_count_wrap();
        load_seed(1'b1, 11'h7FE, 1'b0);
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
        check(pat0 == 8'hFF && pat2 == 11'h7FF, "R7", "count increment", pat2, 11'h7FF);
        @(negedge clk);
        enable = 1'b0;
        check(pat0 == 8'h00 && pat2 == 11'h000 && pat1 == 4'h0, "R7", "count wrap to zero", pat2, 0);
    endtask

    // R2: load wins over enable, and load restarts the period count
    task automatic t_load_restart();
        int early = 0;
        load_seed(1'b0, 11'h2C5, 1'b1);
        check(pat0 == 8'hC5 && pat2 == 11'h2C5, "R2", "load with enable high", pat0, 8'hC5);
        @(negedge clk); enable = 1'b1;
        repeat (37) @(negedge clk);
        load = 1'b1; seed = 11'h03A;
        @(negedge clk);
        load = 1'b0;
        check(pat0 == 8'h3A && !done0, "R2", "reload mid period", pat0, 8'h3A);
        for (int k = 1; k < 256; k++) begin
            @(negedge clk);
            if (done0) early++;
        end
        check(early == 0, "R2", "done before full period after reload", early, 0);
        @(negedge clk);
        enable = 1'b0;
        check(done0 && pat0 == 8'h3A, "R8", "done after 256 steps from reload", done0, 1);
    endtask

    // R8: pause in the middle does not disturb the period
    task automatic t_pause();
        int early = 0;
        load_seed(1'b0, 11'h123, 1'b0);
        @(negedge clk); enable = 1'b1;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            if (done0) early++;
        end
        enable = 1'b0;
        repeat (7) begin
            @(negedge clk);
            if (done0) early++;
        end
        enable = 1'b1;
        for (int k = 101; k < 256; k++) begin
            @(negedge clk);
            if (done0) early++;
        end
        check(early == 0, "R8", "early done around pause", early, 0);
        @(negedge clk);
        check(done0 && pat0 == 8'h23, "R8", "done after paused period", pat0, 8'h23);
        @(negedge clk);
        enable = 1'b0;
        check(!done0, "R8", "done lasts one cycle", done0, 0);
    endtask

    // R6 (shift) or R7 (count) uniqueness plus R8 done placement, over 2048 steps
    task automatic t_sweep(input logic m, input logic [10:0] s, input string req);
        bit seen0 [256];
        bit seen1 [16];
        bit seen2 [2048];
        int dup0 = 0, dup1 = 0, dup2 = 0;
        int bad0 = 0, bad1 = 0, bad2 = 0;
        foreach (seen0[i]) seen0[i] = 1'b0;
        foreach (seen1[i]) seen1[i] = 1'b0;
        foreach (seen2[i]) seen2[i] = 1'b0;
        load_seed(m, s, 1'b0);
        check(pat0 == s[7:0] && pat1 == s[3:0] && pat2 == s, "R2", "sweep seed loaded", pat2, s);
        seen0[pat0] = 1'b1; seen1[pat1] = 1'b1; seen2[pat2] = 1'b1;
        enable = 1'b1;
        for (int k = 1; k <= 2048; k++) begin
            @(negedge clk);
            if (k < 256)  begin if (seen0[pat0]) dup0++; seen0[pat0] = 1'b1; end
            if (k < 16)   begin if (seen1[pat1]) dup1++; seen1[pat1] = 1'b1; end
            if (k < 2048) begin if (seen2[pat2]) dup2++; seen2[pat2] = 1'b1; end
            if (k % 256 == 0) begin if (!done0 || pat0 != s[7:0]) bad0++; end
            else if (done0) bad0++;
            if (k % 16 == 0) begin if (!done1 || pat1 != s[3:0]) bad1++; end
            else if (done1) bad1++;
            if (k == 2048) begin if (!done2 || pat2 != s) bad2++; end
            else if (done2) bad2++;
        end
        enable = 1'b0;
        check(dup0 == 0, req, "u0 repeated patterns in one period", dup0, 0);
        check(dup1 == 0, req, "u1 repeated patterns in one period", dup1, 0);
        check(dup2 == 0, req, "u2 repeated patterns in one period", dup2, 0);
        check(bad0 == 0, "R8", "u0 misplaced done", bad0, 0);
        check(bad1 == 0, "R8", "u1 misplaced done", bad1, 0);
        check(bad2 == 0, "R8", "u2 misplaced done", bad2, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hold();
        t_zero_splice();
        t_count_wrap();
        t_load_restart();
        t_pause();
        t_sweep(1'b0, 11'h5A3, "R6");
        t_sweep(1'b0, 11'h000, "R6");
        t_sweep(1'b1, 11'h7FE, "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule